// File: doc/BRIEF.md
# Memory-Format Instruction Sequencer

This block steers the front of a 32-bit stack processor. Each cycle it takes the instruction word that the fetch port returned and decodes the three-bit type field. It then does one of three things: it redirects the fetch stream (call, jump, jump-if-zero), it computes an effective address as a base operand plus a 16-bit unsigned offset, or it passes an arithmetic-format word through. The sum either goes straight to a destination register (the two address-forming instructions) or drives a data-memory transfer one cycle later (load and store). The next fetch address is always picked from the incremented program counter, a branch target, or the top of the return stack.

The surrounding datapath supplies the base operand, the value to be stored, the flag bit, the return-stack top and the load data. The source and destination selector fields go out so that this datapath can route them. The stack-pointer control field goes out unchanged during the execute cycle. A call asks for a return-stack push of the address after the call. Any non-control word can also end the current subroutine by setting its return bit.

The controller has three states. `ST_BOOT` is entered on reset and issues the first fetch at the reset vector. It always moves to `ST_RUN`. `ST_RUN` executes one instruction per cycle and issues the next fetch. It stays in `ST_RUN` except on a load or store, which moves it to `ST_XFER`. `ST_XFER` performs the data access with the fetch port idle, ignores the instruction input, and always returns to `ST_RUN`.

Top module: `stack_memfmt_sequencer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released (`ST_BOOT`), `fetch_en_o`=1 and `fetch_addr_o`=RESET_PC (default 0). `mem_req_o`, `wb_en_o` and `rpush_o` are all 0. This also holds when reset arrives during a data-transfer cycle.
- R2: The type is taken from bits 31:29: 0 call, 1 jump, 2 jump-if-zero, 3 arithmetic, 4 load, 5 store, 6 address-form low, 7 address-form high.
- R3: A call finishes in one cycle. It fetches from bits 28:0 zero-extended, and it raises `rpush_o` with `rpush_data_o` = address of the call + 1.
- R4: A jump fetches from bits 28:0 zero-extended, and the flag has no effect on it.
- R5: A jump-if-zero fetches its target when `flag_i`=0. Otherwise it fetches the address of the jump + 1.
- R6: Address-form low writes base + bits 15:0 to the destination given by bits 23:20 in the same cycle (`wb_en_o`=1, `wb_dst_o`, `wb_data_o`), with no memory request.
- R7: Address-form high writes base + (bits 15:0 shifted left by 16) in the same cycle.
- R8: A load has an execute cycle, in which the next fetch is issued and no data request is made. This is followed by one transfer cycle: `mem_req_o`=1, `mem_we_o`=0, address = base + offset, `fetch_en_o`=0. In that cycle `mem_rdata_i` is written to the destination that was latched, and the instruction input is ignored.
- R9: A store behaves like a load, except that in the transfer cycle `mem_we_o`=1 and `mem_wdata_o`=`store_data_i`, and there is no register write.
- R10: For types 3 to 7, bit 28 set makes the next fetch use `rstk_top_i` instead of address + 1. This combines with the instruction's own work in the same cycle.
- R11: In the execute cycle of types 3 to 7, `stk_ctl_o` = bits 19:16 and `src_sel_o` = bits 27:24. During control-flow and transfer cycles `stk_ctl_o` is 0.
- R12: The offset sum wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_i | input | 32 | Instruction word returned by the last fetch |
| base_i | input | 32 | Base operand read through `src_sel_o` |
| store_data_i | input | 32 | Value to store, read through `dst_sel_o` |
| flag_i | input | 1 | Condition flag |
| rstk_top_i | input | 32 | Return-stack top |
| mem_rdata_i | input | 32 | Load data, same cycle |
| fetch_en_o | output | 1 | Instruction fetch request |
| fetch_addr_o | output | 32 | Instruction fetch address |
| mem_req_o | output | 1 | Data access request |
| mem_we_o | output | 1 | Data access is a write |
| mem_addr_o | output | 32 | Data address |
| mem_wdata_o | output | 32 | Data to write |
| src_sel_o | output | 4 | Source operand selector |
| dst_sel_o | output | 4 | Destination/store-data selector |
| stk_ctl_o | output | 4 | Stack-pointer control field |
| wb_en_o | output | 1 | Register write enable |
| wb_dst_o | output | 4 | Register write selector |
| wb_data_o | output | 32 | Register write data |
| rpush_o | output | 1 | Return-stack push request |
| rpush_data_o | output | 32 | Value pushed (return address) |

## Verification
Two things can fall in the same cycle: a subroutine return through bit 28, and either the address computation of a load/store or the register write of an address-form instruction. The bench provokes both pairings. One is a store with bit 28 set and an offset that wraps the sum. The other is an address-form low with bit 28 set. It checks that the return-stack address is fetched in the execute cycle while the sum still reaches the destination or appears as the data address one cycle later. It also checks that a transfer cycle ignores a word that would otherwise be a taken branch or a call.

// File: rtl/seq_pkg.sv
package seq_pkg;

    localparam int INSN_W  = 32;
    localparam int KIND_W  = 3;
    localparam int SEL_W   = 4;
    localparam int OFF_W   = 16;
    localparam int TGT_W   = 29;
    localparam int RET_BIT = 28;
    localparam int SRC_LSB = 24;
    localparam int DST_LSB = 20;
    localparam int STK_LSB = 16;

    typedef enum logic [KIND_W-1:0] {
        IT_CALL   = 3'd0,
        IT_JUMP   = 3'd1,
        IT_JZ     = 3'd2,
        IT_ARITH  = 3'd3,
        IT_LOAD   = 3'd4,
        IT_STORE  = 3'd5,
        IT_LEA_LO = 3'd6,
        IT_LEA_HI = 3'd7
    } itype_e;

    typedef enum logic [1:0] {
        ST_BOOT = 2'd0,
        ST_RUN  = 2'd1,
        ST_XFER = 2'd2
    } seq_state_e;

    typedef struct packed {
        itype_e             kind;
        logic               is_ctrl;
        logic               is_mem;
        logic               is_lea;
        logic               ret;
        logic [SEL_W-1:0]   src;
        logic [SEL_W-1:0]   dst;
        logic [SEL_W-1:0]   stk;
        logic [OFF_W-1:0]   off;
        logic [TGT_W-1:0]   tgt;
    } dec_t;

endpackage

// File: rtl/seq_decode.sv
module seq_decode
    import seq_pkg::*;
(
    input  logic [INSN_W-1:0] instr_i,
    output dec_t              dec_o
);

    itype_e kind;

    assign kind = itype_e'(instr_i[INSN_W-1 -: KIND_W]);

    always_comb begin
        dec_o.kind    = kind;
        dec_o.is_ctrl = (kind == IT_CALL) || (kind == IT_JUMP) || (kind == IT_JZ);
        dec_o.is_mem  = (kind == IT_LOAD) || (kind == IT_STORE);
        dec_o.is_lea  = (kind == IT_LEA_LO) || (kind == IT_LEA_HI);
        dec_o.ret     = instr_i[RET_BIT];
        dec_o.src     = instr_i[SRC_LSB +: SEL_W];
        dec_o.dst     = instr_i[DST_LSB +: SEL_W];
        dec_o.stk     = instr_i[STK_LSB +: SEL_W];
        dec_o.off     = instr_i[OFF_W-1:0];
        dec_o.tgt     = instr_i[TGT_W-1:0];
    end

endmodule

// File: rtl/seq_agu.sv
module seq_agu #(
    parameter int DW    = 32,
    parameter int OFF_W = 16
) (
    input  logic [DW-1:0]    base_i,
    input  logic [OFF_W-1:0] off_i,
    input  logic             high_i,
    output logic [DW-1:0]    sum_o
);

    localparam int PAD_LO = DW - OFF_W;

    logic [DW-1:0] off_lo;
    logic [DW-1:0] off_hi;
    logic [DW-1:0] addend;

    assign off_lo = {{PAD_LO{1'b0}}, off_i};

    generate
        if (DW >= 2 * OFF_W) begin : g_wide
            localparam int PAD_HI = DW - 2 * OFF_W;
            if (PAD_HI > 0) begin : g_pad
                assign off_hi = {{PAD_HI{1'b0}}, off_i, {OFF_W{1'b0}}};
            end else begin : g_nopad
                assign off_hi = {off_i, {OFF_W{1'b0}}};
            end
        end else begin : g_narrow
            assign off_hi = {off_i[PAD_LO-1:0], {OFF_W{1'b0}}};
        end
    endgenerate

    assign addend = high_i ? off_hi : off_lo;
    assign sum_o  = base_i + addend;

endmodule

// File: rtl/seq_next_pc.sv
module seq_next_pc #(
    parameter int AW    = 32,
    parameter int TGT_W = 29
) (
    input  logic [AW-1:0]    pc_i,
    input  logic             is_ctrl_i,
    input  logic             is_cond_i,
    input  logic             ret_i,
    input  logic             flag_i,
    input  logic [TGT_W-1:0] tgt_i,
    input  logic [AW-1:0]    rtop_i,
    output logic [AW-1:0]    pc_inc_o,
    output logic [AW-1:0]    next_o
);

    localparam int TPAD = AW - TGT_W;

    logic [AW-1:0] tgt_ext;
    logic          take;

    assign pc_inc_o = pc_i + {{(AW-1){1'b0}}, 1'b1};
    assign tgt_ext  = {{TPAD{1'b0}}, tgt_i};
    assign take     = is_ctrl_i && (!is_cond_i || !flag_i);

    always_comb begin
        if (take) begin
            next_o = tgt_ext;
        end else if (!is_ctrl_i && ret_i) begin
            next_o = rtop_i;
        end else begin
            next_o = pc_inc_o;
        end
    end

endmodule

// File: rtl/stack_memfmt_sequencer.sv
module stack_memfmt_sequencer
    import seq_pkg::*;
#(
    parameter int          AW       = 32,
    parameter int          DW       = 32,
    parameter logic [31:0] RESET_PC = 32'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INSN_W-1:0] instr_i,
    input  logic [DW-1:0]     base_i,
    input  logic [DW-1:0]     store_data_i,
    input  logic              flag_i,
    input  logic [AW-1:0]     rstk_top_i,
    input  logic [DW-1:0]     mem_rdata_i,
    output logic              fetch_en_o,
    output logic [AW-1:0]     fetch_addr_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [AW-1:0]     mem_addr_o,
    output logic [DW-1:0]     mem_wdata_o,
    output logic [SEL_W-1:0]  src_sel_o,
    output logic [SEL_W-1:0]  dst_sel_o,
    output logic [SEL_W-1:0]  stk_ctl_o,
    output logic              wb_en_o,
    output logic [SEL_W-1:0]  wb_dst_o,
    output logic [DW-1:0]     wb_data_o,
    output logic              rpush_o,
    output logic [AW-1:0]     rpush_data_o
);

    seq_state_e       state_q, state_d;
    logic [AW-1:0]    pc_q, pc_d;
    logic [AW-1:0]    ea_q, ea_d;
    logic [SEL_W-1:0] xdst_q, xdst_d;
    logic             xwr_q, xwr_d;

    dec_t             dec;
    logic [DW-1:0]    sum;
    logic [AW-1:0]    pc_inc;
    logic [AW-1:0]    pc_next;

    seq_decode i_decode (
        .instr_i (instr_i),
        .dec_o   (dec)
    );

    seq_agu #(
        .DW    (DW),
        .OFF_W (OFF_W)
    ) i_agu (
        .base_i (base_i),
        .off_i  (dec.off),
        .high_i (dec.kind == IT_LEA_HI),
        .sum_o  (sum)
    );

    seq_next_pc #(
        .AW    (AW),
        .TGT_W (TGT_W)
    ) i_next_pc (
        .pc_i      (pc_q),
        .is_ctrl_i (dec.is_ctrl),
        .is_cond_i (dec.kind == IT_JZ),
        .ret_i     (dec.ret),
        .flag_i    (flag_i),
        .tgt_i     (dec.tgt),
        .rtop_i    (rstk_top_i),
        .pc_inc_o  (pc_inc),
        .next_o    (pc_next)
    );

    // State and context registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BOOT;
            pc_q    <= RESET_PC[AW-1:0];
            ea_q    <= '0;
            xdst_q  <= '0;
            xwr_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
            ea_q    <= ea_d;
            xdst_q  <= xdst_d;
            xwr_q   <= xwr_d;
        end
    end

    // Transitions and context updates
    always_comb begin
        state_d = state_q;
        pc_d    = pc_q;
        ea_d    = ea_q;
        xdst_d  = xdst_q;
        xwr_d   = xwr_q;
        unique case (state_q)
            ST_BOOT: begin
                state_d = ST_RUN;
            end
            ST_RUN: begin
                pc_d = pc_next;
                if (dec.is_mem) begin
                    state_d = ST_XFER;
                    ea_d    = sum[AW-1:0];
                    xdst_d  = dec.dst;
                    xwr_d   = (dec.kind == IT_STORE);
                end
            end
            ST_XFER: begin
                state_d = ST_RUN;
            end
            default: begin
                state_d = ST_BOOT;
            end
        endcase
    end

    // Outputs
    always_comb begin
        fetch_en_o   = 1'b0;
        fetch_addr_o = pc_q;
        mem_req_o    = 1'b0;
        mem_we_o     = 1'b0;
        mem_addr_o   = ea_q;
        mem_wdata_o  = store_data_i;
        src_sel_o    = '0;
        dst_sel_o    = '0;
        stk_ctl_o    = '0;
        wb_en_o      = 1'b0;
        wb_data_o    = sum;
        rpush_o      = 1'b0;
        rpush_data_o = pc_inc;
        unique case (state_q)
            ST_BOOT: begin
                fetch_en_o   = 1'b1;
                fetch_addr_o = pc_q;
            end
            ST_RUN: begin
                fetch_en_o   = 1'b1;
                fetch_addr_o = pc_next;
                if (!dec.is_ctrl) begin
                    src_sel_o = dec.src;
                    dst_sel_o = dec.dst;
                    stk_ctl_o = dec.stk;
                end
                if (dec.is_lea) begin
                    wb_en_o   = 1'b1;
                    wb_data_o = sum;
                end
                if (dec.kind == IT_CALL) begin
                    rpush_o = 1'b1;
                end
            end
            ST_XFER: begin
                mem_req_o  = 1'b1;
                mem_we_o   = xwr_q;
                mem_addr_o = ea_q;
                dst_sel_o  = xdst_q;
                wb_en_o    = !xwr_q;
                wb_data_o  = mem_rdata_i;
            end
            default: begin
                fetch_en_o = 1'b0;
            end
        endcase
        wb_dst_o = dst_sel_o;
    end

endmodule

// File: rtl/stack_memfmt_sequencer_chk.sv
module stack_memfmt_sequencer_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fetch_en_o,
    input logic [AW-1:0] fetch_addr_o,
    input logic          mem_req_o,
    input logic          mem_we_o,
    input logic [3:0]    stk_ctl_o,
    input logic          wb_en_o,
    input logic          rpush_o,
    input logic [AW-1:0] rpush_data_o
);

    AST_XFER_HOLDS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> !fetch_en_o); // R8

    AST_XFER_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |=> !mem_req_o); // R8

    AST_XFER_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> $past(fetch_en_o)); // R8

    AST_STORE_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> (mem_req_o && !wb_en_o)); // R9

    AST_PUSH_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        rpush_o |-> (fetch_en_o && !wb_en_o && !mem_req_o)); // R3

    AST_PUSH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (rpush_o && $past(fetch_en_o)) |-> (rpush_data_o == $past(fetch_addr_o) + 1'b1)); // R3

    AST_STK_QUIET_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (stk_ctl_o == 4'd0)); // R11

endmodule

bind stack_memfmt_sequencer stack_memfmt_sequencer_chk #(.AW(AW)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_en_o   (fetch_en_o),
    .fetch_addr_o (fetch_addr_o),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .stk_ctl_o    (stk_ctl_o),
    .wb_en_o      (wb_en_o),
    .rpush_o      (rpush_o),
    .rpush_data_o (rpush_data_o)
);

// File: tb/test_stack_memfmt_sequencer.sv
`timescale 1ns/1ps
module test_stack_memfmt_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr, base, sdata, rtop, rdata;
    logic        flag;
    logic        fen, mreq, mwe, wben, push;
    logic [31:0] faddr, maddr, mwdata, wbdata, pdata;
    logic [3:0]  srcs, dsts, stk, wbdst;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    stack_memfmt_sequencer i_stack_memfmt_sequencer (
        .clk(clk), .rst_n(rst_n), .instr_i(instr), .base_i(base),
        .store_data_i(sdata), .flag_i(flag), .rstk_top_i(rtop),
        .mem_rdata_i(rdata), .fetch_en_o(fen), .fetch_addr_o(faddr),
        .mem_req_o(mreq), .mem_we_o(mwe), .mem_addr_o(maddr),
        .mem_wdata_o(mwdata), .src_sel_o(srcs), .dst_sel_o(dsts),
        .stk_ctl_o(stk), .wb_en_o(wben), .wb_dst_o(wbdst),
        .wb_data_o(wbdata), .rpush_o(push), .rpush_data_o(pdata)
    );

    typedef struct packed {
        logic [31:0] instr;
        logic [31:0] base;
        logic        flag;
        logic [31:0] rtop;
        logic [31:0] rdata;
        logic [31:0] sdata;
        logic        fen;
        logic [31:0] faddr;
        logic        wben;
        logic [3:0]  wbdst;
        logic [31:0] wbdata;
        logic        push;
        logic [31:0] pdata;
        logic        mreq;
        logic        mwe;
        logic [31:0] maddr;
        logic [3:0]  stk;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t TAB [NV] = '{
        '{32'hE0101234, 32'h0, 1'b0, 32'h0, 32'h0, 32'h0, 1'b1, 32'h1, 1'b1, 4'd1, 32'h12340000, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 4'h0},
        '{32'hC1105678, 32'h12340000, 1'b0, 32'h0, 32'h0, 32'h0, 1'b1, 32'h2, 1'b1, 4'd1, 32'h12345678, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 4'h0},
        '{32'h00000100, 32'h0, 1'b0, 32'h0, 32'h0, 32'h0, 1'b1, 32'h100, 1'b0, 4'd0, 32'h0, 1'b1, 32'h3, 1'b0, 1'b0, 32'h0, 4'h0},
        '{32'h40000200, 32'h0, 1'b1, 32'h0, 32'h0, 32'h0, 1'b1, 32'h101, 1'b0, 4'd0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 4'h0},
        '{32'h5FFFFFFF, 32'h0, 1'b0, 32'h0, 32'h0, 32'h0, 1'b1, 32'h1FFFFFFF, 1'b0, 4'd0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 4'h0},
        '{32'h20000040, 32'h0, 1'b1, 32'h0, 32'h0, 32'h0, 1'b1, 32'h40, 1'b0, 4'd0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 4'h0},
        '{32'h82350010, 32'h1000, 1'b0, 32'h0, 32'h0, 32'h0, 1'b1, 32'h41, 1'b0, 4'd0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 4'h5},
        '{32'h40000000, 32'h0, 1'b0, 32'h0, 32'hCAFEF00D, 32'h0, 1'b0, 32'h0, 1'b1, 4'd3, 32'hCAFEF00D, 1'b0, 32'h0, 1'b1, 1'b0, 32'h1010, 4'h0},
        '{32'hB14CFFFF, 32'hFFFFFFF0, 1'b0, 32'h777, 32'h0, 32'h0, 1'b1, 32'h777, 1'b0, 4'd0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 4'hC},
        '{32'h00000000, 32'h0, 1'b0, 32'h0, 32'h0, 32'hA5A5A5A5, 1'b0, 32'h0, 1'b0, 4'd0, 32'h0, 1'b0, 32'h0, 1'b1, 1'b1, 32'h0000FFEF, 4'h0},
        '{32'h70030000, 32'h0, 1'b0, 32'h900, 32'h0, 32'h0, 1'b1, 32'h900, 1'b0, 4'd0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 4'h3},
        '{32'hD0000003, 32'h5, 1'b0, 32'h50, 32'h0, 32'h0, 1'b1, 32'h50, 1'b1, 4'd0, 32'h8, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 4'h0},
        '{32'h00000000, 32'h0, 1'b0, 32'h0, 32'h0, 32'h0, 1'b1, 32'h0, 1'b0, 4'd0, 32'h0, 1'b1, 32'h51, 1'b0, 1'b0, 32'h0, 4'h0}
    };

    function automatic string tag_of(input int i);
        case (i)
            0:  return "R7";
            1:  return "R6";
            2:  return "R3";
            3:  return "R5";
            4:  return "R5";
            5:  return "R4/R2";
            6:  return "R11";
            7:  return "R8";
            8:  return "R10";
            9:  return "R9/R12";
            10: return "R10";
            11: return "R10";
            default: return "R3";
        endcase
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input logic [31:0] i, input logic [31:0] b, input logic f,
                         input logic [31:0] rt, input logic [31:0] rd, input logic [31:0] sd);
        instr = i; base = b; flag = f; rtop = rt; rdata = rd; sdata = sd;
    endtask

    initial begin
        drive(32'h0, 32'h0, 1'b0, 32'h0, 32'h0, 32'h0);
        repeat (3) @(negedge clk);
        // R1: reset held
        #1;
        chk("R1", "fetch_en in reset", {31'b0, fen}, 32'h1);
        chk("R1", "fetch_addr in reset", faddr, 32'h0);
        chk("R1", "mem_req in reset", {31'b0, mreq}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: boot cycle
        chk("R1", "boot fetch_en", {31'b0, fen}, 32'h1);
        chk("R1", "boot fetch_addr", faddr, 32'h0);
        chk("R1", "boot wb/push/req", {29'b0, wben, push, mreq}, 32'h0);

        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            drive(TAB[k].instr, TAB[k].base, TAB[k].flag, TAB[k].rtop, TAB[k].rdata, TAB[k].sdata);
            #1;
            chk(tag_of(k), "fetch_en", {31'b0, fen}, {31'b0, TAB[k].fen});
            if (TAB[k].fen) chk(tag_of(k), "fetch_addr", faddr, TAB[k].faddr);
            chk(tag_of(k), "wb_en", {31'b0, wben}, {31'b0, TAB[k].wben});
            if (TAB[k].wben) begin
                chk(tag_of(k), "wb_dst", {28'b0, wbdst}, {28'b0, TAB[k].wbdst});
                chk(tag_of(k), "wb_data", wbdata, TAB[k].wbdata);
            end
            chk(tag_of(k), "rpush", {31'b0, push}, {31'b0, TAB[k].push});
            if (TAB[k].push) chk(tag_of(k), "rpush_data", pdata, TAB[k].pdata);
            chk(tag_of(k), "mem_req/we", {30'b0, mreq, mwe}, {30'b0, TAB[k].mreq, TAB[k].mwe});
            if (TAB[k].mreq) chk(tag_of(k), "mem_addr", maddr, TAB[k].maddr);
            if (TAB[k].mwe) chk(tag_of(k), "mem_wdata", mwdata, TAB[k].sdata);
            chk(tag_of(k), "stk_ctl", {28'b0, stk}, {28'b0, TAB[k].stk});
        end

        // R11: source selector in execute cycle of a load (src=9)
        @(negedge clk);
        drive(32'h89000004, 32'h20, 1'b0, 32'h0, 32'h0, 32'h0);
        #1;
        chk("R11", "src_sel", {28'b0, srcs}, 32'h9);
        // R1: reset arriving in transfer cycle
        @(negedge clk);
        drive(32'h0, 32'h0, 1'b0, 32'h0, 32'h0, 32'h0);
        #1;
        chk("R8", "transfer addr 0x24", maddr, 32'h24);
        rst_n = 1'b0;
        #1;
        chk("R1", "reset mid-transfer mem_req", {31'b0, mreq}, 32'h0);
        chk("R1", "reset mid-transfer fetch", {fen, faddr[30:0]}, 32'h80000000);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule